// File: doc/BRIEF.md
# Complex Zero-Lag Correlation Accumulator

This block forms the zero-lag complex cross-correlation between a sample stream y and a reference stream s. Each component of both streams arrives as a sign-magnitude word. On every cycle with the valid strobe high, the block multiplies y by the complex conjugate of s. It does this with four real multipliers. Each one takes its sign from the operand sign bits and sends only the magnitudes through a recursive approximate magnitude multiplier. The block then adds the signed real and imaginary terms into two wide accumulators.

After a programmable number of valid samples, the two sums are copied to the outputs and a done pulse is raised for one cycle. Accumulation restarts at once with the next valid sample, so no sample is lost between blocks. A synchronous clear discards a partial block. The degree of approximation inside the magnitude multiplier is a parameter, and an exact multiplier is one of its settings.

Top module: `cxcorr_zero_lag`

## Requirements
- R1: Each input word is 9 bits. Bit 8 is the sign (1 = negative) and bits 7:0 are the magnitude, so the word's value is (-1)^sign × magnitude. A word with magnitude zero has value zero whatever its sign bit, and a product with a zero-magnitude operand adds exactly zero.
- R2: The magnitude product splits each 8-bit magnitude into 2-bit digits, where digit k is bits [2k+1:2k]. It sums cell(a_i, b_j) << 2(i+j) over all digit pairs. A cell returns the exact 2-bit product, except that a cell with i+j < APPROX_LEVEL (default 2) returns 7 for 3×3.
- R3: The sign of each real product is the XOR of its two operand sign bits.
- R4: The real output accumulates yr·sr + yi·si for every accepted sample.
- R5: The imaginary output accumulates yi·sr − yr·si for every accepted sample.
- R6: After blk_len accepted samples (a blk_len of 0 acts as 1), the complete sums appear on the outputs and done is high for exactly one cycle, the cycle after the clock edge that accepted the last sample. The next block starts with the next accepted sample, and no sample is dropped.
- R7: A cycle with in_vld low changes neither the sums nor the sample count.
- R8: A high clr at a clock edge zeroes the partial sums and the sample count, and any sample offered in that cycle is discarded. The outputs keep their last dumped values, and done stays low in the following cycle.
- R9: The accumulators are 33 bits wide, and full-scale inputs of either sign over 16384 samples are reported exactly.
- R10: After reset, done is low and both outputs are zero.
- R11: Between done pulses, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of partial sums and count |
| in_vld | input | 1 | Sample strobe |
| y_re | input | 9 | y real part, sign-magnitude |
| y_im | input | 9 | y imaginary part, sign-magnitude |
| s_re | input | 9 | Reference real part, sign-magnitude |
| s_im | input | 9 | Reference imaginary part, sign-magnitude |
| blk_len | input | 15 | Samples per block (0 treated as 1) |
| done | output | 1 | One-cycle pulse when a block is dumped |
| acc_re | output | 33 | Signed real sum of the last block |
| acc_im | output | 33 | Signed imaginary sum of the last block |

## Verification
A wrong sample count inside the block shows at the ports as a done pulse that comes early or late, so it appears at the end of the first block it affects. A corrupted partial sum, a lost sample at a block boundary, or a wrong sign or approximation cell stays hidden until the next dump, and then shows as a wrong acc_re or acc_im value. For that reason the bench uses short blocks, including single-sample blocks that expose each multiplier cell at once, and a full-length block that exposes the accumulator width.

// File: rtl/cxcorr_pkg.sv
package cxcorr_pkg;
   // digit width of the recursive multiplier leaf cell
   localparam int unsigned CELL_W = 2;

   // which operand pair feeds each of the four real multipliers
   typedef enum logic [1:0] {
      PAIR_RR = 2'd0,   // y_re * s_re
      PAIR_II = 2'd1,   // y_im * s_im
      PAIR_IR = 2'd2,   // y_im * s_re
      PAIR_RI = 2'd3    // y_re * s_im
   } pair_e;
endpackage

// File: rtl/mag2_cell.sv
module mag2_cell #(
   parameter bit APPROX = 1'b0
) (
   input  logic [1:0] a,
   input  logic [1:0] b,
   output logic [3:0] p
);
   generate
      if (APPROX) begin : g_apx
         // 3x3 gives 7, all other products are exact
         always_comb begin
            p[0] = a[0] & b[0];
            p[1] = (a[1] & b[0]) | (a[0] & b[1]);
            p[2] = a[1] & b[1];
            p[3] = 1'b0;
         end
      end else begin : g_exact
         always_comb begin
            p[0] = a[0] & b[0];
            p[1] = (a[1] & b[0]) ^ (a[0] & b[1]);
            p[2] = a[1] & b[1] & ~(a[0] & b[0]);
            p[3] = a[1] & a[0] & b[1] & b[0];
         end
      end
   endgenerate
endmodule

// File: rtl/approx_mag_mult.sv
module approx_mag_mult #(
   parameter int unsigned MAG_W        = 8,
   parameter int unsigned APPROX_LEVEL = 2
) (
   input  logic [MAG_W-1:0]   a,
   input  logic [MAG_W-1:0]   b,
   output logic [2*MAG_W-1:0] p
);
   import cxcorr_pkg::*;
   localparam int unsigned DIG  = MAG_W / CELL_W;
   localparam int unsigned PW   = 2 * MAG_W;
   localparam int unsigned CPW  = 2 * CELL_W;

   if (MAG_W % CELL_W != 0 || MAG_W < CELL_W) begin : g_bad_w
      $error("approx_mag_mult: MAG_W must be a positive multiple of the cell width");
   end

   logic [CPW-1:0] cell_p [DIG][DIG];

   for (genvar i = 0; i < DIG; i++) begin : g_row
      for (genvar j = 0; j < DIG; j++) begin : g_col
         mag2_cell #(.APPROX((i + j) < APPROX_LEVEL)) u_cell (
            .a (a[CELL_W*i +: CELL_W]),
            .b (b[CELL_W*j +: CELL_W]),
            .p (cell_p[i][j])
         );
      end
   end

   always_comb begin
      p = '0;
      for (int i = 0; i < DIG; i++) begin
         for (int j = 0; j < DIG; j++) begin
            p = p + (PW'(cell_p[i][j]) << (CELL_W * (i + j)));
         end
      end
   end
endmodule

// File: rtl/sm_real_mult.sv
module sm_real_mult #(
   parameter int unsigned MAG_W        = 8,
   parameter int unsigned APPROX_LEVEL = 2
) (
   input  logic                      a_sgn,
   input  logic [MAG_W-1:0]          a_mag,
   input  logic                      b_sgn,
   input  logic [MAG_W-1:0]          b_mag,
   output logic signed [2*MAG_W:0]   prod
);
   localparam int unsigned PW = 2 * MAG_W;

   logic [PW-1:0] mag_p;
   logic          neg;

   approx_mag_mult #(.MAG_W(MAG_W), .APPROX_LEVEL(APPROX_LEVEL)) u_mag (
      .a (a_mag),
      .b (b_mag),
      .p (mag_p)
   );

   // a zero magnitude never produces a negative result
   assign neg = (a_sgn ^ b_sgn) & (|a_mag) & (|b_mag);

   always_comb begin
      if (neg) prod = -$signed({1'b0, mag_p});
      else     prod =  $signed({1'b0, mag_p});
   end
endmodule

// File: rtl/corr_accum.sv
module corr_accum #(
   parameter int unsigned TERM_W = 18,
   parameter int unsigned ACC_W  = 33,
   parameter int unsigned CNT_W  = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     vld,
   input  logic [CNT_W-1:0]         len,
   input  logic signed [TERM_W-1:0] term_re,
   input  logic signed [TERM_W-1:0] term_im,
   output logic                     done,
   output logic signed [ACC_W-1:0]  out_re,
   output logic signed [ACC_W-1:0]  out_im
);
   if (ACC_W <= TERM_W) begin : g_bad_acc
      $error("corr_accum: accumulator must be wider than a term");
   end

   logic signed [ACC_W-1:0] acc_re, acc_im;
   logic signed [ACC_W-1:0] sum_re, sum_im;
   logic [CNT_W-1:0]        cnt, eff_len;
   logic [CNT_W:0]          cnt_nx;
   logic                    last;

   always_comb begin
      sum_re  = acc_re + {{(ACC_W-TERM_W){term_re[TERM_W-1]}}, term_re};
      sum_im  = acc_im + {{(ACC_W-TERM_W){term_im[TERM_W-1]}}, term_im};
      eff_len = (len == '0) ? CNT_W'(1) : len;
      cnt_nx  = {1'b0, cnt} + 1'b1;
      last    = cnt_nx >= {1'b0, eff_len};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
         cnt    <= '0;
         done   <= 1'b0;
         out_re <= '0;
         out_im <= '0;
      end else if (clr) begin
         acc_re <= '0;
         acc_im <= '0;
         cnt    <= '0;
         done   <= 1'b0;
      end else if (vld) begin
         if (last) begin
            out_re <= sum_re;
            out_im <= sum_im;
            acc_re <= '0;
            acc_im <= '0;
            cnt    <= '0;
            done   <= 1'b1;
         end else begin
            acc_re <= sum_re;
            acc_im <= sum_im;
            cnt    <= cnt_nx[CNT_W-1:0];
            done   <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/cxcorr_zero_lag.sv
module cxcorr_zero_lag #(
   parameter int unsigned MAG_W        = 8,
   parameter int unsigned T_MAX        = 16384,
   parameter int unsigned APPROX_LEVEL = 2,
   localparam int unsigned WORD_W      = MAG_W + 1,
   localparam int unsigned CNT_W       = $clog2(T_MAX) + 1,
   localparam int unsigned ACC_W       = 2 * MAG_W + $clog2(T_MAX) + 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    in_vld,
   input  logic [WORD_W-1:0]       y_re,
   input  logic [WORD_W-1:0]       y_im,
   input  logic [WORD_W-1:0]       s_re,
   input  logic [WORD_W-1:0]       s_im,
   input  logic [CNT_W-1:0]        blk_len,
   output logic                    done,
   output logic signed [ACC_W-1:0] acc_re,
   output logic signed [ACC_W-1:0] acc_im
);
   import cxcorr_pkg::*;
   localparam int unsigned PROD_W = 2 * MAG_W + 1;
   localparam int unsigned TERM_W = PROD_W + 1;

   if (T_MAX < 2) begin : g_bad_t
      $error("cxcorr_zero_lag: T_MAX must be at least 2");
   end
   if (APPROX_LEVEL > 2 * (MAG_W / CELL_W)) begin : g_bad_apx
      $error("cxcorr_zero_lag: APPROX_LEVEL exceeds the digit-pair range");
   end

   logic [WORD_W-1:0]        op_y [4];
   logic [WORD_W-1:0]        op_s [4];
   logic signed [PROD_W-1:0] prod [4];
   logic signed [TERM_W-1:0] term_re, term_im;

   always_comb begin
      op_y[PAIR_RR] = y_re;  op_s[PAIR_RR] = s_re;
      op_y[PAIR_II] = y_im;  op_s[PAIR_II] = s_im;
      op_y[PAIR_IR] = y_im;  op_s[PAIR_IR] = s_re;
      op_y[PAIR_RI] = y_re;  op_s[PAIR_RI] = s_im;
   end

   for (genvar k = 0; k < 4; k++) begin : g_mult
      sm_real_mult #(.MAG_W(MAG_W), .APPROX_LEVEL(APPROX_LEVEL)) u_mult (
         .a_sgn (op_y[k][MAG_W]),
         .a_mag (op_y[k][MAG_W-1:0]),
         .b_sgn (op_s[k][MAG_W]),
         .b_mag (op_s[k][MAG_W-1:0]),
         .prod  (prod[k])
      );
   end

   // conjugated reference: re = rr + ii, im = ir - ri
   always_comb begin
      term_re = TERM_W'(prod[PAIR_RR]) + TERM_W'(prod[PAIR_II]);
      term_im = TERM_W'(prod[PAIR_IR]) - TERM_W'(prod[PAIR_RI]);
   end

   corr_accum #(.TERM_W(TERM_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .vld     (in_vld),
      .len     (blk_len),
      .term_re (term_re),
      .term_im (term_im),
      .done    (done),
      .out_re  (acc_re),
      .out_im  (acc_im)
   );
endmodule

// File: rtl/cxcorr_checker.sv
module cxcorr_checker #(
   parameter int unsigned CNT_W = 15,
   parameter int unsigned ACC_W = 33
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             in_vld,
   input logic [CNT_W-1:0] blk_len,
   input logic             done,
   input logic [ACC_W-1:0] acc_re,
   input logic [ACC_W-1:0] acc_im
);
   logic [CNT_W:0] seen;
   logic [CNT_W:0] need;

   assign need = (blk_len == '0) ? (CNT_W+1)'(1) : {1'b0, blk_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   seen <= '0;
      else if (clr)                 seen <= '0;
      else if (in_vld) begin
         if (seen + 1'b1 >= need)   seen <= '0;
         else                       seen <= seen + 1'b1;
      end
   end

   // R11: outputs move only together with done
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(acc_re) && $stable(acc_im)));

   // R8: a clear is never followed by a dump
   assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !done);

   // R7: an idle cycle is never followed by a dump
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_vld && !clr) |=> !done);

   // R6: a one-sample block dumps at once
   assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !clr && blk_len <= 1) |=> done);

   // R6: no dump before the block is complete
   assert_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !clr && (seen + 1'b1 < need)) |=> !done);
endmodule

bind cxcorr_zero_lag cxcorr_checker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .in_vld  (in_vld),
   .blk_len (blk_len),
   .done    (done),
   .acc_re  (acc_re),
   .acc_im  (acc_im)
);

// File: tb/tb_cxcorr_zero_lag.sv
module tb_cxcorr_zero_lag;
   localparam int AL = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        in_vld = 1'b0;
   logic [8:0]  y_re = '0, y_im = '0, s_re = '0, s_im = '0;
   logic [14:0] blk_len = 15'd1;
   logic        done;
   logic signed [32:0] acc_re, acc_im;

   int checks = 0;
   int misses = 0;

   longint m_acc_re = 0, m_acc_im = 0, m_out_re = 0, m_out_im = 0;
   int     m_cnt = 0;

   always #10 clk = ~clk;

   cxcorr_zero_lag dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
      .y_re(y_re), .y_im(y_im), .s_re(s_re), .s_im(s_im),
      .blk_len(blk_len), .done(done), .acc_re(acc_re), .acc_im(acc_im)
   );

   function automatic longint mag_ref(input logic [7:0] a, input logic [7:0] b);
      longint r = 0;
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            int ai = int'(a[2*i +: 2]);
            int bj = int'(b[2*j +: 2]);
            int c = ai * bj;
            if ((i + j) < AL && ai == 3 && bj == 3) c = 7;
            r += longint'(c) << (2 * (i + j));
         end
      end
      return r;
   endfunction

   function automatic longint sm_ref(input logic [8:0] x, input logic [8:0] y);
      longint m = mag_ref(x[7:0], y[7:0]);
      return (x[8] ^ y[8]) ? -m : m;
   endfunction

   function automatic logic [8:0] rnd_word();
      logic [8:0] w = 9'($urandom);
      if ($urandom_range(0, 9) == 0) w[7:0] = 8'd0;
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model, sample after the edge
   task automatic step(input bit v, input bit c, input logic [8:0] yr, input logic [8:0] yi,
                       input logic [8:0] sr, input logic [8:0] si, input string req);
      bit exp_done = 0;
      int eff = (blk_len == 0) ? 1 : int'(blk_len);
      @(negedge clk);
      in_vld = v; clr = c; y_re = yr; y_im = yi; s_re = sr; s_im = si;
      if (c) begin
         m_acc_re = 0; m_acc_im = 0; m_cnt = 0;
      end else if (v) begin
         m_acc_re += sm_ref(yr, sr) + sm_ref(yi, si);
         m_acc_im += sm_ref(yi, sr) - sm_ref(yr, si);
         m_cnt++;
         if (m_cnt >= eff) begin
            exp_done = 1; m_out_re = m_acc_re; m_out_im = m_acc_im;
            m_acc_re = 0; m_acc_im = 0; m_cnt = 0;
         end
      end
      @(posedge clk); #1;
      check(done == exp_done, req, "done", longint'(done), longint'(exp_done));
      check(longint'(acc_re) == m_out_re && longint'(acc_im) == m_out_im, req,
            "re/im (re shown)", longint'(acc_re), m_out_re);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      #5;
      // R10: reset state
      check(done == 1'b0 && acc_re == 0 && acc_im == 0, "R10", "reset", longint'(acc_re), 0);
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R2: single-sample blocks expose individual cells
      blk_len = 15'd1;
      step(1, 0, 9'd3,   9'd0, 9'd3,  9'd0, "R2");   // 3x3 -> 7
      check(acc_re == 7, "R2", "low cell 3x3", longint'(acc_re), 7);
      step(1, 0, 9'd12,  9'd0, 9'd3,  9'd0, "R2");   // i+j=1 -> 28
      check(acc_re == 28, "R2", "mid cell", longint'(acc_re), 28);
      step(1, 0, 9'd12,  9'd0, 9'd12, 9'd0, "R2");   // i+j=2 exact 144
      check(acc_re == 144, "R2", "exact cell", longint'(acc_re), 144);
      // R3 and R5: sign and conjugation
      step(1, 0, 9'h105, 9'd0, 9'd0, 9'd7, "R5");    // im = -( -5*7 )
      check(acc_im == 35 && acc_re == 0, "R5", "conj im", longint'(acc_im), 35);
      step(1, 0, 9'h105, 9'h106, 9'd2, 9'h103, "R3");
      step(1, 0, 9'd0,   9'd4, 9'd0, 9'd9, "R4");
      check(acc_re == 36, "R4", "yi*si", longint'(acc_re), 36);
      // R1: negative zero contributes nothing
      step(1, 0, 9'h100, 9'h100, 9'h100, 9'd5, "R1");
      check(acc_re == 0 && acc_im == 0, "R1", "neg zero", longint'(acc_re), 0);
      // R6: length zero behaves as one
      blk_len = 15'd0;
      step(1, 0, 9'd20, 9'd1, 9'd3, 9'd2, "R6");

      // R6/R7: random streams with gaps, blocks of 64
      blk_len = 15'd64;
      for (int n = 0; n < 700; n++)
         step($urandom_range(0, 3) != 0, 0, rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R6");
      // R7: long idle stretch changes nothing
      for (int n = 0; n < 20; n++)
         step(0, 0, rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R7");
      // R8: clear mid-block, including with valid high
      blk_len = 15'd5;
      for (int n = 0; n < 3; n++) step(1, 0, rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R8");
      step(1, 1, 9'd255, 9'd255, 9'd255, 9'd255, "R8");
      for (int n = 0; n < 12; n++) step(1, 0, rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R8");
      // R4/R5: back-to-back random single and short blocks
      blk_len = 15'd3;
      for (int n = 0; n < 90; n++) step(1, 0, rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R5");
      blk_len = 15'd256;
      for (int n = 0; n < 600; n++)
         step($urandom_range(0, 4) != 0, $urandom_range(0, 299) == 0,
              rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R4");

      // R9: full-scale positive then negative over 16384 samples
      step(0, 1, 9'd0, 9'd0, 9'd0, 9'd0, "R9");
      blk_len = 15'd16384;
      for (int n = 0; n < 16384; n++) step(1, 0, 9'd255, 9'h1FF, 9'd255, 9'h1FF, "R9");
      check(acc_re == 2 * 16384 * mag_ref(8'd255, 8'd255), "R9", "full +",
            longint'(acc_re), 2 * 16384 * mag_ref(8'd255, 8'd255));
      for (int n = 0; n < 16384; n++) step(1, 0, 9'd255, 9'd255, 9'h1FF, 9'h1FF, "R9");
      check(acc_re == -2 * 16384 * mag_ref(8'd255, 8'd255), "R9", "full -",
            longint'(acc_re), -2 * 16384 * mag_ref(8'd255, 8'd255));

      $display("  == %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
   end
endmodule